// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Combiner

This block merges five non-maskable event sources into a single request line for the processor: an external NMI pin, a detector for a stopped oscillator, an error from the independent watchdog (counter underflow or a refresh outside its allowed window), and two voltage monitors. Each source gets a sticky flag, latched when its event pulse arrives while that source is armed. The request line stays high for as long as any flag is set.

Software reaches the block through three byte registers at consecutive addresses. One reads the flags. One arms sources, and an armed source cannot be disarmed until reset. One drops flags when 1s are written to it. All three registers place the sources at the same bit positions. Bit 2 is skipped, so the sources occupy bits 0, 1, 3, 4 and 5. A priority encoder reports which pending source the handler should serve first, which saves a search through the flag byte in the handler.

Top module: `nmi_combiner`

## Requirements
- R1: After reset, the flag and arm registers read 0x00, `nmi_req` is 0 and `src_idx` is 5.
- R2: All three registers use one bit layout: bit 0 is the pin, bit 1 the oscillator-stop source, bit 3 the watchdog, bit 4 monitor 1 and bit 5 monitor 2. `evt_i[0..4]` follow that same source order. Bits 2, 6 and 7 always read 0 and have no effect when written.
- R3: Address 1 is the arm register. A write to it ORs the written bits into the stored value. Writing 0 to an armed bit leaves it set until reset.
- R4: A flag sets on the clock edge where its event pulse is high and its arm bit was already 1 before that edge. An event on a disarmed source, or in the same cycle as the write that arms it, leaves its flag at 0.
- R5: A set flag stays set without further events until it is cleared.
- R6: Address 2 is the clear register. Writing 1 to a bit drops the matching flag on that edge, and writing 0 has no effect. If the source's event arrives in the same cycle as the clear, the flag stays set. Address 2 reads 0x00.
- R7: Address 0 is the flag register and is read-only: writes to it change nothing. Address 3 reads 0x00 and ignores writes.
- R8: `nmi_req` is 1 exactly when at least one flag is set.
- R9: `src_idx` gives the highest-priority set flag, in the order pin=0, oscillator=1, watchdog=2, monitor 1=3, monitor 2=4. It reads 5 when no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | Event pulses: [0] pin, [1] oscillator stop, [2] watchdog, [3] monitor 1, [4] monitor 2 |
| addr | input | 2 | Register address: 0 flags, 1 arm, 2 clear |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| nmi_req | output | 1 | Combined non-maskable request |
| src_idx | output | 3 | Index of the highest-priority pending source, 5 for none |

## Verification
All state is two bytes of flip-flops, and both bytes can be read back one cycle after any change. A flag that is wrongly set or wrongly kept moves `nmi_req` and `src_idx` at once, and shows in the flag byte on the next read. A lost arm bit first shows as a flag that fails to latch on the next event of that source. For that reason the bench compares every output against its model on every cycle, not only at the end of a scenario. The cases that matter most are an event colliding with a clear of the same source, an event in the same cycle as the write that arms it, and writes to the unused bit positions.

// File: rtl/nmi_combiner.sv
module nmi_combiner #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter logic [AW-1:0] A_FLAG = 2'd0,
  parameter logic [AW-1:0] A_ARM  = 2'd1,
  parameter logic [AW-1:0] A_CLR  = 2'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    evt_i,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          nmi_req,
  output logic [2:0]    src_idx
);
  localparam logic [DW-1:0] MASK     = DW'(8'h3B);
  localparam logic [2:0]    IDX_NONE = 3'd5;

  logic [DW-1:0] flag_q, arm_q;
  logic [DW-1:0] evt_b, arm_set, clr_b;

  always_comb begin
    evt_b    = '0;
    evt_b[0] = evt_i[0];
    evt_b[1] = evt_i[1];
    evt_b[3] = evt_i[2];
    evt_b[4] = evt_i[3];
    evt_b[5] = evt_i[4];
  end

  assign arm_set = (wr_en && addr == A_ARM) ? (wdata & MASK) : '0;
  assign clr_b   = (wr_en && addr == A_CLR) ? (wdata & MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_b) | (evt_b & arm_q);
      arm_q  <= arm_q | arm_set;
    end
  end

  always_comb begin
    unique case (addr)
      A_FLAG:  rdata = flag_q;
      A_ARM:   rdata = arm_q;
      default: rdata = '0;
    endcase
  end

  assign nmi_req = |flag_q;

  always_comb begin
    if      (flag_q[0]) src_idx = 3'd0;
    else if (flag_q[1]) src_idx = 3'd1;
    else if (flag_q[3]) src_idx = 3'd2;
    else if (flag_q[4]) src_idx = 3'd3;
    else if (flag_q[5]) src_idx = 3'd4;
    else                src_idx = IDX_NONE;
  end
endmodule

module nmi_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] evt_i,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       nmi_req,
  input logic [2:0] src_idx,
  input logic [7:0] flag_q,
  input logic [7:0] arm_q
);
  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 8'hC4) == 8'h00);

  // R3
  arm_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (arm_q & $past(arm_q)) == $past(arm_q));

  // R6
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && evt_i == 5'd0) |=> (flag_q & $past(wdata)) == 8'h00);

  // R8
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_req |-> src_idx == 3'd5);

  // R9
  busy_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> src_idx < 3'd5);

  // R4
  no_event_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == 5'd0) |=> (flag_q & ~$past(flag_q)) == 8'h00);

  // R7
  flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && evt_i == 5'd0) |=> $stable(flag_q));
endmodule

bind nmi_combiner nmi_combiner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .nmi_req(nmi_req), .src_idx(src_idx),
  .flag_q(flag_q), .arm_q(arm_q)
);

// File: tb/sim_nmi_combiner.sv
module sim_nmi_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_i = '0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       nmi_req;
  logic [2:0] src_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit m_flag[5];
  bit m_arm[5];
  int pos[5] = '{0, 1, 3, 4, 5};

  always #5 clk = ~clk;

  nmi_combiner u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .nmi_req(nmi_req), .src_idx(src_idx)
  );

  function automatic logic [7:0] pack(input bit v[5]);
    logic [7:0] b = '0;
    for (int k = 0; k < 5; k++) if (v[k]) b[pos[k]] = 1'b1;
    return b;
  endfunction

  task automatic compare(input string tag);
    logic [7:0] exp_rd;
    logic [2:0] exp_idx = 3'd5;
    logic       exp_req = 1'b0;
    case (addr)
      2'd0:    exp_rd = pack(m_flag);
      2'd1:    exp_rd = pack(m_arm);
      default: exp_rd = 8'h00;
    endcase
    for (int k = 4; k >= 0; k--) if (m_flag[k]) begin exp_idx = 3'(k); exp_req = 1'b1; end
    checks++;
    if (rdata !== exp_rd || nmi_req !== exp_req || src_idx !== exp_idx) begin
      errors++;
      $display("FAIL %s: rdata=%h req=%b idx=%0d, expected rdata=%h req=%b idx=%0d",
               tag, rdata, nmi_req, src_idx, exp_rd, exp_req, exp_idx);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin m_flag[k] = 0; m_arm[k] = 0; end
  endtask

  task automatic cyc(input logic [1:0] a, input logic w, input logic [7:0] d,
                     input logic [4:0] e, input string tag);
    addr = a; wr_en = w; wdata = d; evt_i = e;
    @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      if (e[k] && m_arm[k]) m_flag[k] = 1;
      else if (w && a == 2'd2 && d[pos[k]]) m_flag[k] = 0;
    end
    for (int k = 0; k < 5; k++) if (w && a == 2'd1 && d[pos[k]]) m_arm[k] = 1;
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(a, 1'b0, 8'h00, 5'd0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; evt_i = '0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    addr = 2'd0; #1; compare("R1 flags after reset");
    addr = 2'd1; #1; compare("R1 arm after reset");

    cyc(0, 0, 8'h00, 5'h1F, "R4 events while disarmed");
    cyc(1, 1, 8'h21, 5'd0, "R3 arm pin and monitor 2");
    cyc(1, 1, 8'h00, 5'd0, "R3 write 0 keeps arm");
    cyc(1, 1, 8'hC4, 5'd0, "R2 unused arm bits");
    cyc(0, 0, 8'h00, 5'b10001, "R4 armed events latch");
    rd(0, "R5 flags sticky");
    rd(0, "R5 flags sticky again");
    cyc(2, 1, 8'h01, 5'd0, "R6 clear pin flag");
    rd(0, "R9 index moves to monitor 2");
    cyc(2, 1, 8'h00, 5'd0, "R6 clear write of 0");
    cyc(0, 1, 8'h00, 5'd0, "R7 write to flag register");
    cyc(3, 1, 8'hFF, 5'd0, "R7 write to address 3");
    rd(0, "R7 flags unchanged");
    cyc(2, 1, 8'h21, 5'b10001, "R6 event beats clear");
    rd(0, "R6 flags after collision");
    cyc(2, 1, 8'h21, 5'd0, "R8 all clear drops request");
    cyc(1, 1, 8'hFF, 5'd0, "R3 arm all");
    for (int k = 4; k >= 0; k--) begin
      cyc(0, 0, 8'h00, 5'(1 << k), "R9 priority per source");
    end
    cyc(2, 1, 8'h3B, 5'd0, "R8 clear every flag");

    do_reset();
    cyc(1, 1, 8'h02, 5'b00010, "R4 arm and event same cycle");
    rd(0, "R4 no flag from same-cycle arm");
    cyc(0, 0, 8'h00, 5'b00010, "R4 later event latches");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic w = ($urandom_range(0, 3) == 0);
      logic [7:0] d = 8'($urandom);
      logic [4:0] e = ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'd0;
      if (a == 2'd1 && $urandom_range(0, 7) != 0) w = 1'b0;
      cyc(a, w, d, e, "R9 random traffic");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule